// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array with Activity Masking

The block is a small grid of one-bit processing elements (4 rows by 4 columns by default) that all obey one broadcast command at a time. Each element owns a bit-addressed local memory, a carry flag, a pair of comparison flags and an activity flag. A multi-bit command names the operand fields by their base bit address and a length. The controller then steps through the fields one bit per clock, and every element applies the same bit operation to its own data. An element whose activity flag is clear still sees the broadcast, but it writes nothing to its memory.

Data enters and leaves as bit planes: one bit per element, with bit `e` of a plane belonging to the element at row `e / COLS`, column `e % COLS`. A plane write stores `plane_in` at one memory address. A plane read places one memory bit of every element on `plane_out`. Two outputs summarise the activity flags combinationally: a Some/None flag and a count of active elements. A caller uses them to end loops or to size sparse data. A two-way conditional is built from a compare, the true-branch commands, an activity inversion and the false-branch commands.

The controller has three states. IDLE accepts a command that is not a no-op and moves to STEP. STEP issues one bit operation per cycle; after the last bit it returns to IDLE, or goes to COMMIT when the command is a compare. COMMIT merges the compare result into the activity flags and returns to IDLE.

Top module: `simd_bitserial_array`

## Requirements
- R1: An element whose activity flag is 0 leaves its local memory unchanged under plane write, add and neighbour shift, while active elements store their results.
- R2: Add (op code 4) forms D = A + B over `cmd_len` bits, least significant bit first, modulo 2^len, at bit addresses base+i. Every element's carry is cleared when the command is accepted, so a carry left by an earlier add never enters the result.
- R3: Add and shift keep `busy` high for exactly `cmd_len` cycles and compare for `cmd_len`+1 cycles. The single-step ops (1 plane write, 2 set activity, 3 invert activity, 7 plane read) take one cycle, and a length of 0 counts as 1.
- R4: Shift (op code 6) copies field A of the neighbouring element into field D over `cmd_len` bits. Direction code 0 takes from the row above, 1 from the row below, 2 from the next column, 3 from the previous column. An element with no neighbour on that side receives 0.
- R5: Set activity (op 2) loads every activity flag from `plane_in`, whatever its current value. Invert activity (op 3) complements every flag.
- R6: Compare (op 5) evaluates unsigned A > B, most significant bit first. Each activity flag then becomes its old value AND the result, so an inactive element never becomes active.
- R7: `some_active` is the OR of all activity flags and `active_count` is their population count. Both follow the flags with no delay.
- R8: A two-way conditional (compare, true-branch add, invert, false-branch add) gives each element the result of exactly one branch. Its busy time is the sum of the individual command times.
- R9: After reset every element is active, every memory bit and `plane_out` are 0, and `busy` is 0. A plane read (op 7) returns on `plane_out` the bits that a plane write stored at that address.
- R10: A command presented while `busy` is high is ignored, and op 0 (no-op) is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present, taken when idle |
| cmd_op | input | 3 | Operation code |
| cmd_dir | input | 2 | Shift direction code |
| cmd_len | input | LEN_W (6) | Field length in bits |
| cmd_addr_a | input | AW (5) | Base bit address of operand A |
| cmd_addr_b | input | AW (5) | Base bit address of operand B |
| cmd_addr_d | input | AW (5) | Base bit address of destination / write address |
| plane_in | input | N (16) | Bit plane for plane write and set activity |
| busy | output | 1 | Command in progress |
| plane_out | output | N (16) | Bit plane from the last plane read |
| some_active | output | 1 | OR of activity flags |
| active_count | output | CNT_W (5) | Number of active elements |

## Verification
Each element holds its own pair of operands. The pairs include one whose sum overflows the field, one equal pair, and pairs where A and B differ only in low or only in high bits. These pairs separate a correct add from a wrong carry order, and a correct compare from a wrong bit order. Activity patterns (odd columns, the top row, the top half, none, a single element) expose leaks past the mask and mistakes in the count. All four shift directions are run, so a swapped direction or a missing zero at the grid edge shows in the data read back. Timing is checked by counting busy cycles for each kind of command, including a length of 0 and a command injected while busy.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRPL   = 3'd1,
        OP_SETACT = 3'd2,
        OP_INVACT = 3'd3,
        OP_ADD    = 3'd4,
        OP_GT     = 3'd5,
        OP_SHIFT  = 3'd6,
        OP_RDPL   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_S = 2'd1,
        DIR_E = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [3:0] {
        U_NONE,
        U_WRPL,
        U_SETACT,
        U_INVACT,
        U_ADD,
        U_GT,
        U_GTCOMMIT,
        U_SHIFT,
        U_RDPL
    } uop_e;

    function automatic logic is_multi(op_e op);
        return (op == OP_ADD) || (op == OP_GT) || (op == OP_SHIFT);
    endfunction

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
    import simd_pkg::*;
#(
    parameter int N     = 16,
    parameter int AW    = 5,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  op_e              cmd_op,
    input  dir_e             cmd_dir,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [AW-1:0]    cmd_a,
    input  logic [AW-1:0]    cmd_b,
    input  logic [AW-1:0]    cmd_d,
    input  logic [N-1:0]     plane_in,
    output logic             busy,
    output logic             clr,
    output uop_e             uop,
    output dir_e             dir,
    output logic [AW-1:0]    bit_a,
    output logic [AW-1:0]    bit_b,
    output logic [AW-1:0]    bit_d,
    output logic [N-1:0]     plane_bc
);

    typedef enum logic [1:0] {S_IDLE, S_STEP, S_COMMIT} state_e;

    state_e           state, state_nx;
    op_e              op_q;
    dir_e             dir_q;
    logic [LEN_W-1:0] last_q, cnt, last_in, off;
    logic [AW-1:0]    a_q, b_q, d_q;
    logic [N-1:0]     plane_q;
    logic             accept, at_last;

    assign accept  = (state == S_IDLE) && cmd_valid && (cmd_op != OP_NOP);
    assign last_in = (is_multi(cmd_op) && (cmd_len != '0)) ? cmd_len - LEN_W'(1) : '0;
    assign at_last = (cnt == last_q);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept) state_nx = S_STEP;
            S_STEP:   if (at_last) state_nx = (op_q == OP_GT) ? S_COMMIT : S_IDLE;
            S_COMMIT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // command latch and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            dir_q   <= DIR_N;
            last_q  <= '0;
            cnt     <= '0;
            a_q     <= '0;
            b_q     <= '0;
            d_q     <= '0;
            plane_q <= '0;
        end else if (accept) begin
            op_q    <= cmd_op;
            dir_q   <= cmd_dir;
            last_q  <= last_in;
            cnt     <= '0;
            a_q     <= cmd_a;
            b_q     <= cmd_b;
            d_q     <= cmd_d;
            plane_q <= plane_in;
        end else if (state == S_STEP && !at_last) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    // compare walks from the top bit down, everything else from bit 0 up
    assign off = (op_q == OP_GT) ? (last_q - cnt) : cnt;

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        clr      = accept;
        dir      = dir_q;
        plane_bc = plane_q;
        bit_a    = a_q + off[AW-1:0];
        bit_b    = b_q + off[AW-1:0];
        bit_d    = d_q + off[AW-1:0];
        uop      = U_NONE;
        unique case (state)
            S_IDLE:   uop = U_NONE;
            S_COMMIT: uop = U_GTCOMMIT;
            S_STEP: begin
                unique case (op_q)
                    OP_WRPL:   uop = U_WRPL;
                    OP_SETACT: uop = U_SETACT;
                    OP_INVACT: uop = U_INVACT;
                    OP_ADD:    uop = U_ADD;
                    OP_GT:     uop = U_GT;
                    OP_SHIFT:  uop = U_SHIFT;
                    OP_RDPL:   uop = U_RDPL;
                    default:   uop = U_NONE;
                endcase
            end
            default: uop = U_NONE;
        endcase
    end

    a_r10_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && cmd_op != OP_NOP) |=> busy);

    a_r10_nop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && (!cmd_valid || cmd_op == OP_NOP)) |=> !busy);

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP) |-> (cnt <= last_q));

    a_r10_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP && $past(state) == S_STEP) |-> $stable(op_q));

endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter int MEM_BITS = 32,
    parameter int AW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  uop_e          uop,
    input  logic [AW-1:0] bit_a,
    input  logic [AW-1:0] bit_b,
    input  logic [AW-1:0] bit_d,
    input  logic          plane_bit,
    input  logic          nbr_in,
    output logic          rd_a,
    output logic          act,
    output logic          pout
);

    logic [MEM_BITS-1:0] mem;
    logic                carry, still_eq, gt_flag, rd_b;

    assign rd_a = mem[bit_a];
    assign rd_b = mem[bit_b];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem      <= '0;
            act      <= 1'b1;
            carry    <= 1'b0;
            still_eq <= 1'b1;
            gt_flag  <= 1'b0;
            pout     <= 1'b0;
        end else begin
            if (clr) begin
                carry    <= 1'b0;
                still_eq <= 1'b1;
                gt_flag  <= 1'b0;
            end
            unique case (uop)
                U_WRPL:     if (act) mem[bit_d] <= plane_bit;
                U_SETACT:   act <= plane_bit;
                U_INVACT:   act <= ~act;
                U_ADD: begin
                    if (act) mem[bit_d] <= rd_a ^ rd_b ^ carry;
                    carry <= (rd_a & rd_b) | (carry & (rd_a ^ rd_b));
                end
                U_GT: begin
                    if (still_eq && rd_a && !rd_b) begin
                        gt_flag  <= 1'b1;
                        still_eq <= 1'b0;
                    end else if (still_eq && !rd_a && rd_b) begin
                        still_eq <= 1'b0;
                    end
                end
                U_GTCOMMIT: act <= act & gt_flag;
                U_SHIFT:    if (act) mem[bit_d] <= nbr_in;
                U_RDPL:     pout <= rd_a;
                default: ;
            endcase
        end
    end

    a_r1_inactive_mem_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> $stable(mem));

    a_r6_commit_never_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == U_GTCOMMIT && !act) |=> !act);

    a_r2_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry);

endmodule

// File: rtl/simd_summary.sv
module simd_summary #(
    parameter int N     = 16,
    parameter int CNT_W = 5
) (
    input  logic [N-1:0]     act,
    output logic             some,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(act[i]);
        end
        some = |act;
    end

endmodule

// File: rtl/simd_bitserial_array.sv
module simd_bitserial_array
    import simd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int MEM_BITS = 32,
    localparam int N       = ROWS * COLS,
    localparam int AW      = $clog2(MEM_BITS),
    localparam int LEN_W   = AW + 1,
    localparam int CNT_W   = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [1:0]       cmd_dir,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [AW-1:0]    cmd_addr_a,
    input  logic [AW-1:0]    cmd_addr_b,
    input  logic [AW-1:0]    cmd_addr_d,
    input  logic [N-1:0]     plane_in,
    output logic             busy,
    output logic [N-1:0]     plane_out,
    output logic             some_active,
    output logic [CNT_W-1:0] active_count
);

    logic          clr;
    uop_e          uop;
    dir_e          dir;
    logic [AW-1:0] bit_a, bit_b, bit_d;
    logic [N-1:0]  plane_bc, rd_a_v, act_v, pout_v;

    simd_ctrl #(.N(N), .AW(AW), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e'(cmd_op)),
        .cmd_dir   (dir_e'(cmd_dir)),
        .cmd_len   (cmd_len),
        .cmd_a     (cmd_addr_a),
        .cmd_b     (cmd_addr_b),
        .cmd_d     (cmd_addr_d),
        .plane_in  (plane_in),
        .busy      (busy),
        .clr       (clr),
        .uop       (uop),
        .dir       (dir),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .bit_d     (bit_d),
        .plane_bc  (plane_bc)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int E = r * COLS + c;
            logic fn, fs, fe, fw, nbr;

            if (r > 0)        begin : g_n assign fn = rd_a_v[E-COLS]; end
            else              begin : g_n0 assign fn = 1'b0; end
            if (r < ROWS - 1) begin : g_s assign fs = rd_a_v[E+COLS]; end
            else              begin : g_s0 assign fs = 1'b0; end
            if (c < COLS - 1) begin : g_e assign fe = rd_a_v[E+1]; end
            else              begin : g_e0 assign fe = 1'b0; end
            if (c > 0)        begin : g_w assign fw = rd_a_v[E-1]; end
            else              begin : g_w0 assign fw = 1'b0; end

            always_comb begin
                unique case (dir)
                    DIR_N:   nbr = fn;
                    DIR_S:   nbr = fs;
                    DIR_E:   nbr = fe;
                    DIR_W:   nbr = fw;
                    default: nbr = 1'b0;
                endcase
            end

            simd_pe #(.MEM_BITS(MEM_BITS), .AW(AW)) u_pe (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (clr),
                .uop       (uop),
                .bit_a     (bit_a),
                .bit_b     (bit_b),
                .bit_d     (bit_d),
                .plane_bit (plane_bc[E]),
                .nbr_in    (nbr),
                .rd_a      (rd_a_v[E]),
                .act       (act_v[E]),
                .pout      (pout_v[E])
            );
        end
    end

    simd_summary #(.N(N), .CNT_W(CNT_W)) u_sum (
        .act   (act_v),
        .some  (some_active),
        .count (active_count)
    );

    assign plane_out = pout_v;

    a_r7_some_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        some_active == (active_count != '0));

    a_r5_setact_loads_plane: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == U_SETACT) |=> (act_v == $past(plane_bc)));

    a_r5_invact_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (uop == U_INVACT) |=> (act_v == ~$past(act_v)));

endmodule

// File: tb/tb_simd_bitserial_array.sv
module tb_simd_bitserial_array;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int N    = ROWS * COLS;
    localparam int W    = 6;
    localparam int FA   = 0;
    localparam int FB   = 8;
    localparam int FD   = 16;
    localparam int FE   = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_dir = '0;
    logic [5:0]  cmd_len = '0;
    logic [4:0]  cmd_addr_a = '0, cmd_addr_b = '0, cmd_addr_d = '0;
    logic [N-1:0] plane_in = '0;
    logic        busy;
    logic [N-1:0] plane_out;
    logic        some_active;
    logic [4:0]  active_count;

    int n_tests = 0;
    int n_fail  = 0;
    int va[N], vb[N], rd[N], wv[N];

    always #2.5 clk = ~clk;

    simd_bitserial_array dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dir(cmd_dir), .cmd_len(cmd_len), .cmd_addr_a(cmd_addr_a),
        .cmd_addr_b(cmd_addr_b), .cmd_addr_d(cmd_addr_d), .plane_in(plane_in),
        .busy(busy), .plane_out(plane_out), .some_active(some_active),
        .active_count(active_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int dr, input int len, input int a,
                         input int b, input int d, input logic [N-1:0] pl,
                         output int cyc);
        @(negedge clk);
        cmd_op = 3'(op); cmd_dir = 2'(dr); cmd_len = 6'(len);
        cmd_addr_a = 5'(a); cmd_addr_b = 5'(b); cmd_addr_d = 5'(d);
        plane_in = pl; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic write_field(input int base);
        int cyc;
        for (int i = 0; i < W; i++) begin
            logic [N-1:0] pl;
            for (int e = 0; e < N; e++) pl[e] = wv[e][i];
            issue(1, 0, 1, 0, 0, base + i, pl, cyc);
        end
    endtask

    task automatic read_field(input int base);
        int cyc;
        for (int e = 0; e < N; e++) rd[e] = 0;
        for (int i = 0; i < W; i++) begin
            issue(7, 0, 1, base + i, 0, 0, '0, cyc);
            for (int e = 0; e < N; e++) rd[e] |= int'(plane_out[e]) << i;
        end
    endtask

    task automatic all_active();
        int cyc;
        issue(2, 0, 1, 0, 0, 0, '1, cyc);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(some_active == 1'b1, "R9 reset some_active", int'(some_active), 1);
        chk(active_count == 5'd16, "R9 reset count", int'(active_count), 16);
        chk(plane_out == '0, "R9 reset plane_out", int'(plane_out), 0);
    endtask

    task automatic t_plane();
        int cyc;
        issue(1, 0, 1, 0, 0, 31, 16'hA5C3, cyc);
        chk(cyc == 1, "R3 plane write cycles", cyc, 1);
        issue(7, 0, 1, 31, 0, 0, '0, cyc);
        chk(plane_out == 16'hA5C3, "R9 plane readback", int'(plane_out), 16'hA5C3);
    endtask

    task automatic t_add();
        int cyc;
        for (int e = 0; e < N; e++) wv[e] = va[e];
        write_field(FA);
        for (int e = 0; e < N; e++) wv[e] = vb[e];
        write_field(FB);
        issue(4, 0, W, FA, FB, FD, '0, cyc);
        chk(cyc == W, "R3 add cycles", cyc, W);
        read_field(FD);
        for (int e = 0; e < N; e++)
            chk(rd[e] == ((va[e] + vb[e]) & 63), "R2 add sum", rd[e], (va[e] + vb[e]) & 63);
        // element 0 overflowed and left carry=1; a 0+0 add must give 0
        issue(4, 0, W, FE, FE, FE, '0, cyc);
        read_field(FE);
        chk(rd[0] == 0, "R2 carry cleared at start", rd[0], 0);
        issue(4, 0, 0, FE, FE, FE, '0, cyc);
        chk(cyc == 1, "R3 length zero acts as one", cyc, 1);
    endtask

    task automatic t_gating();
        int cyc;
        logic [N-1:0] odd;
        for (int e = 0; e < N; e++) wv[e] = 42;
        write_field(FD);
        for (int e = 0; e < N; e++) odd[e] = ((e % COLS) % 2) == 1;
        issue(2, 0, 1, 0, 0, 0, odd, cyc);
        chk(active_count == 5'd8, "R5 set activity odd columns", int'(active_count), 8);
        issue(4, 0, W, FA, FB, FD, '0, cyc);
        all_active();
        read_field(FD);
        for (int e = 0; e < N; e++) begin
            int exp = odd[e] ? ((va[e] + vb[e]) & 63) : 42;
            chk(rd[e] == exp, "R1 activity gates add", rd[e], exp);
        end
        issue(2, 0, 1, 0, 0, 0, 16'h000F, cyc);
        chk(active_count == 5'd4, "R5 set activity top row", int'(active_count), 4);
        issue(3, 0, 1, 0, 0, 0, '0, cyc);
        chk(active_count == 5'd12, "R5 invert activity", int'(active_count), 12);
        // plane write to inactive elements (top row now inactive)
        issue(1, 0, 1, 0, 0, 31, '0, cyc);
        all_active();
        issue(7, 0, 1, 31, 0, 0, '0, cyc);
        chk(plane_out == 16'h0003, "R1 plane write gated", int'(plane_out), 16'h0003);
    endtask

    task automatic t_gt();
        int cyc, exp_all, exp_half;
        exp_all = 0; exp_half = 0;
        for (int e = 0; e < N; e++) begin
            if (va[e] > vb[e]) exp_all++;
            if (va[e] > vb[e] && e < 8) exp_half++;
        end
        all_active();
        issue(5, 0, W, FA, FB, 0, '0, cyc);
        chk(cyc == W + 1, "R3 compare cycles", cyc, W + 1);
        chk(int'(active_count) == exp_all, "R6 compare count", int'(active_count), exp_all);
        issue(2, 0, 1, 0, 0, 0, 16'h00FF, cyc);
        issue(5, 0, W, FA, FB, 0, '0, cyc);
        chk(int'(active_count) == exp_half, "R6 compare ANDs activity", int'(active_count), exp_half);
    endtask

    task automatic t_shift();
        int cyc;
        all_active();
        for (int dr = 0; dr < 4; dr++) begin
            issue(6, dr, W, FA, 0, FE, '0, cyc);
            chk(cyc == W, "R3 shift cycles", cyc, W);
            read_field(FE);
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    int sr = r, sc = c, exp;
                    case (dr)
                        0: sr = r - 1;
                        1: sr = r + 1;
                        2: sc = c + 1;
                        default: sc = c - 1;
                    endcase
                    if (sr < 0 || sr >= ROWS || sc < 0 || sc >= COLS) exp = 0;
                    else exp = va[sr * COLS + sc];
                    chk(rd[r * COLS + c] == exp, "R4 shift data", rd[r * COLS + c], exp);
                end
            end
        end
    endtask

    task automatic t_summary();
        int cyc;
        issue(2, 0, 1, 0, 0, 0, '0, cyc);
        chk(some_active == 1'b0, "R7 none active flag", int'(some_active), 0);
        chk(active_count == 5'd0, "R7 none active count", int'(active_count), 0);
        issue(2, 0, 1, 0, 0, 0, 16'h0200, cyc);
        chk(some_active == 1'b1, "R7 single active flag", int'(some_active), 1);
        chk(active_count == 5'd1, "R7 single active count", int'(active_count), 1);
    endtask

    task automatic t_branch();
        int c0, c1, c2, c3, tot;
        all_active();
        issue(5, 0, W, FA, FB, 0, '0, c0);
        issue(4, 0, W, FA, FB, FD, '0, c1);
        issue(3, 0, 1, 0, 0, 0, '0, c2);
        issue(4, 0, W, FB, FB, FD, '0, c3);
        tot = c0 + c1 + c2 + c3;
        chk(tot == (W + 1) + W + 1 + W, "R8 branch time is sum", tot, 2 * W + W + 2);
        all_active();
        read_field(FD);
        for (int e = 0; e < N; e++) begin
            int exp = (va[e] > vb[e]) ? ((va[e] + vb[e]) & 63) : ((2 * vb[e]) & 63);
            chk(rd[e] == exp, "R8 branch result", rd[e], exp);
        end
    endtask

    task automatic t_ignore();
        int cyc;
        all_active();
        @(negedge clk);
        cmd_op = 3'd4; cmd_len = 6'(W); cmd_addr_a = 5'(FE); cmd_addr_b = 5'(FE);
        cmd_addr_d = 5'(FE); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 3'd2; plane_in = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(active_count == 5'd16, "R10 command while busy ignored", int'(active_count), 16);
        issue(0, 0, 1, 0, 0, 0, '0, cyc);
        chk(cyc == 0, "R10 no-op not accepted", cyc, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int e = 0; e < N; e++) begin
            va[e] = (e * 13 + 5) & 63;
            vb[e] = (e * 29 + 11) & 63;
        end
        va[0] = 63; vb[0] = 1;
        vb[5] = va[5];
        va[6] = 6'b100000; vb[6] = 6'b011111;
        va[7] = 6'b000001; vb[7] = 6'b000010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plane();
        all_active();
        t_add();
        t_gating();
        t_gt();
        t_shift();
        t_summary();
        t_branch();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule